// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 96 level-sensitive interrupt inputs and presents them to a processor as two request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). The inputs are grouped into banks of 32. Each bank has a raw view of the inputs, a mask, and software-trigger bits. Each source also has its own level register, which holds a 6-bit priority and a bit that routes the source to one of the two request lines.

For each request line, an arbiter picks the winning source among the eligible ones. A source is eligible when it is pending, unmasked, routed to that line and passes the threshold filter. The winner's number is latched into a sorted-source register. Software reads that register to find out which source to service. The latched number stays frozen until software writes an acknowledge bit; only then does the controller pick again.

A single-cycle register bus gives access to all state, using word addresses. A one-shot soft reset returns every register to its reset value.

Top module: `pic_top`

## Requirements
- R1: After reset, every mask bit is 1, `irq_o` and `fiq_o` are 0, and the status register (0x01) reads bit 0 = 1. Both sorted registers (IRQ at 0x02, FIQ at 0x03) read 127 in bits 6:0, which means no active source.
- R2: Source n sits in bank n/32 at bit n%32, and bank b starts at address 0x10+8b. Writing to offset 3 sets every mask bit whose data bit is 1, and writing to offset 2 clears every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged. Offset 1 reads the mask, where 1 means blocked.
- R3: Bank offset 0 reads the raw pending state (input OR software bit), whatever the mask holds.
- R4: Bank offset 6 reads the sources that are pending, unmasked and routed to IRQ. Bank offset 7 reads the sources that are pending, unmasked and routed to FIQ.
- R5: Writing 1s to bank offset 4 sets software-pending bits, and writing 1s to offset 5 clears them. A software bit makes its source pending exactly as an input would.
- R6: The winner is the eligible source with the numerically lowest priority. When two sources have equal priority, the lower source number wins.
- R7: Once latched, a sorted number stays unchanged until an acknowledge is written to the control register (0x04): bit 0 for IRQ, bit 1 for FIQ. After the acknowledge, a fresh selection is made.
- R8: The threshold register (0x05) is 8 bits wide and resets to 0xFF. The value 0xFF turns filtering off. Any other value T admits only sources whose priority is below T.
- R9: The level register of source n is at address 0x40+n. Bits 7:2 hold the priority and bit 0 holds the route (1 = FIQ). Its reset value is 0.
- R10: Writing bit 1 of the config register (0x00) resets all controller state within two cycles. Status bit 0 reads 1 once that reset has finished.
- R11: `irq_o` (or `fiq_o`) is 1 whenever at least one source is eligible for that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data appears one cycle later |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 96 | Interrupt source levels |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 96 sources in three banks, 6-bit priorities and an 8-bit threshold. With three banks, bank selection is exercised on a bank count that is not a power of two, and the top-numbered sources 64 to 95 can be reached.

The 8-bit threshold is wider than the 6-bit priority, so a threshold of 64 or more admits every priority while still being distinct from the all-ones disable value. Random phases mix sparse inputs, mask writes, priorities, routes and thresholds. Directed cases cover equal-priority ties, the latch holding across a priority change, threshold cutoffs and soft reset.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h01;
  localparam logic [ADDR_W-1:0] A_SIRQ = 8'h02;
  localparam logic [ADDR_W-1:0] A_SFIQ = 8'h03;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] A_THR  = 8'h05;
  localparam logic [ADDR_W-1:0] A_BANK = 8'h10;
  localparam logic [ADDR_W-1:0] A_LVL  = 8'h40;

  // per-bank word offsets
  localparam logic [2:0] O_RAW  = 3'd0;
  localparam logic [2:0] O_MASK = 3'd1;
  localparam logic [2:0] O_MCLR = 3'd2;
  localparam logic [2:0] O_MSET = 3'd3;
  localparam logic [2:0] O_SSET = 3'd4;
  localparam logic [2:0] O_SCLR = 3'd5;
  localparam logic [2:0] O_PIRQ = 3'd6;
  localparam logic [2:0] O_PFIQ = 3'd7;
endpackage

// File: rtl/pic_bank.sv
module pic_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_mask,
  input  logic         clr_mask,
  input  logic         set_swi,
  input  logic         clr_swi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask,
  output logic [W-1:0] swi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      swi  <= '0;
    end else begin
      if (set_mask) mask <= mask | wdata;
      else if (clr_mask) mask <= mask & ~wdata;
      if (set_swi) swi <= swi | wdata;
      else if (clr_swi) swi <= swi & ~wdata;
    end
  end

  // R2: written ones take effect on the next cycle
  p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
    set_mask |=> ((mask & $past(wdata)) == $past(wdata)));
  p_mask_clr_r2: assert property (@(posedge clk) disable iff (rst)
    clr_mask |=> ((mask & $past(wdata)) == '0));
  // R5: software release clears the written bits
  p_swi_clr_r5: assert property (@(posedge clk) disable iff (rst)
    clr_swi |=> ((swi & $past(wdata)) == '0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig,
  input  logic [N*PW-1:0] prio_flat,
  output logic          any,
  output logic [IW-1:0] win
);
  logic [PW-1:0] best;

  // scan downward so an equal priority at a lower index takes over
  always_comb begin
    any  = 1'b0;
    best = '1;
    win  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!any || prio_flat[i*PW +: PW] <= best)) begin
        any  = 1'b1;
        best = prio_flat[i*PW +: PW];
        win  = IW'(i);
      end
    end
  end

  // R6: the reported winner is always one of the eligible sources
  p_win_elig_r6: assert property (@(posedge clk) disable iff (rst)
    any |-> elig[win]);
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int BANK_W  = 32,
  parameter int PRIO_W  = 6,
  parameter int THR_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NUM_BANK = NUM_SRC / BANK_W;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int BSEL_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
  localparam logic [IDX_W-1:0] NONE = '1;

  // soft reset
  logic srst_q, int_rst;
  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= bus_we && bus_addr == A_CFG && bus_wdata[1];
  end
  assign int_rst = rst | srst_q;

  // address decode
  logic [ADDR_W-1:0] brel, lrel;
  logic              in_bank, in_lvl;
  logic [BSEL_W-1:0] bsel;
  logic [2:0]        boff;
  logic [IDX_W-1:0]  lidx;
  assign brel    = bus_addr - A_BANK;
  assign lrel    = bus_addr - A_LVL;
  assign in_bank = bus_addr >= A_BANK && brel < ADDR_W'(8 * NUM_BANK);
  assign in_lvl  = bus_addr >= A_LVL && lrel < ADDR_W'(NUM_SRC);
  assign bsel    = brel[BSEL_W+2:3];
  assign boff    = brel[2:0];
  assign lidx    = lrel[IDX_W-1:0];

  // mask and software-pending banks
  logic [NUM_SRC-1:0] mask_all, swi_all, raw_all;
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && in_bank && bsel == BSEL_W'(b);
    pic_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (int_rst),
      .set_mask (hit && boff == O_MSET),
      .clr_mask (hit && boff == O_MCLR),
      .set_swi  (hit && boff == O_SSET),
      .clr_swi  (hit && boff == O_SCLR),
      .wdata    (bus_wdata[BANK_W-1:0]),
      .mask     (mask_all[b*BANK_W +: BANK_W]),
      .swi      (swi_all[b*BANK_W +: BANK_W])
    );
  end
  assign raw_all = src_in | swi_all;

  // per-source level registers and threshold
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] route_q;
  logic [THR_W-1:0]   thr_q;
  always_ff @(posedge clk) begin
    if (int_rst) begin
      for (int n = 0; n < NUM_SRC; n++) prio_q[n] <= '0;
      route_q <= '0;
      thr_q   <= '1;
    end else if (bus_we) begin
      if (in_lvl) begin
        prio_q[lidx]  <= bus_wdata[PRIO_W+1:2];
        route_q[lidx] <= bus_wdata[0];
      end
      if (bus_addr == A_THR) thr_q <= bus_wdata[THR_W-1:0];
    end
  end

  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        thr_ok, pend_live;
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign prio_flat[n*PRIO_W +: PRIO_W] = prio_q[n];
    assign thr_ok[n] = (thr_q == '1) || (THR_W'(prio_q[n]) < thr_q);
  end
  assign pend_live = raw_all & ~mask_all;

  // one arbiter and active latch per output (0 = IRQ, 1 = FIQ)
  logic [NUM_SRC-1:0] elig   [2];
  logic [IDX_W-1:0]   win    [2];
  logic [IDX_W-1:0]   act_num[2];
  logic [1:0]         any, act_vld, out_q;
  for (genvar k = 0; k < 2; k++) begin : g_out
    logic ack;
    assign elig[k] = pend_live & thr_ok & (k == 0 ? ~route_q : route_q);
    assign ack     = bus_we && bus_addr == A_CTRL && bus_wdata[k];
    pic_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_arb (
      .clk       (clk),
      .rst       (int_rst),
      .elig      (elig[k]),
      .prio_flat (prio_flat),
      .any       (any[k]),
      .win       (win[k])
    );
    always_ff @(posedge clk) begin
      if (int_rst) begin
        act_vld[k] <= 1'b0;
        act_num[k] <= NONE;
        out_q[k]   <= 1'b0;
      end else begin
        out_q[k] <= any[k];
        if (ack) act_vld[k] <= 1'b0;
        else if (!act_vld[k] && any[k]) begin
          act_vld[k] <= 1'b1;
          act_num[k] <= win[k];
        end
      end
    end
    // R7: a latched number stays put while it remains valid
    p_hold_r7: assert property (@(posedge clk) disable iff (int_rst)
      ($past(act_vld[k]) && act_vld[k]) |-> act_num[k] == $past(act_num[k]));
  end
  assign irq_o = out_q[0];
  assign fiq_o = out_q[1];

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    int bi;
    rd_mux = '0;
    bi = int'(bsel) * BANK_W;
    if (in_bank) begin
      case (boff)
        O_RAW:          rd_mux[BANK_W-1:0] = raw_all[bi +: BANK_W];
        O_MASK:         rd_mux[BANK_W-1:0] = mask_all[bi +: BANK_W];
        O_SSET, O_SCLR: rd_mux[BANK_W-1:0] = swi_all[bi +: BANK_W];
        O_PIRQ:         rd_mux[BANK_W-1:0] = pend_live[bi +: BANK_W] & ~route_q[bi +: BANK_W];
        O_PFIQ:         rd_mux[BANK_W-1:0] = pend_live[bi +: BANK_W] & route_q[bi +: BANK_W];
        default:        rd_mux = '0;
      endcase
    end else if (in_lvl) begin
      rd_mux[PRIO_W+1:2] = prio_q[lidx];
      rd_mux[0]          = route_q[lidx];
    end else begin
      case (bus_addr)
        A_STAT: rd_mux[0] = ~srst_q;
        A_SIRQ: rd_mux[IDX_W-1:0] = act_vld[0] ? act_num[0] : NONE;
        A_SFIQ: rd_mux[IDX_W-1:0] = act_vld[1] ? act_num[1] : NONE;
        A_THR:  rd_mux[THR_W-1:0] = thr_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/sim_pic_top.sv
module sim_pic_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 96;

  logic        clk = 0, rst = 1;
  logic [7:0]  addr = 0;
  logic        we = 0, re = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NS-1:0] m_src = '0;
  logic        irq_o, fiq_o;

  logic [NS-1:0] m_mask, m_swi, m_fiq;
  logic [5:0]    m_prio [NS];
  logic [7:0]    m_thr;
  int n_cmp = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_top u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_re(re),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_in(m_src),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic model_reset();
    m_mask = '1; m_swi = '0; m_fiq = '0; m_thr = 8'hFF;
    for (int i = 0; i < NS; i++) m_prio[i] = 0;
  endtask

  function automatic int exp_win(bit fq);
    int best = 64, w = 127;
    for (int i = 0; i < NS; i++) begin
      if ((m_src[i] | m_swi[i]) && !m_mask[i] && m_fiq[i] == fq &&
          (m_thr == 8'hFF || {2'b0, m_prio[i]} < m_thr) && m_prio[i] < best) begin
        best = m_prio[i]; w = i;
      end
    end
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0;
    if (a == 8'h00 && d[1]) model_reset();
    else if (a == 8'h05) m_thr = d[7:0];
    else if (a >= 8'h40 && a < 8'h40 + NS) begin
      m_prio[a - 8'h40] = d[7:2]; m_fiq[a - 8'h40] = d[0];
    end else if (a >= 8'h10 && a < 8'h28) begin
      int b = (a - 8'h10) >> 3;
      case (a[2:0])
        3'd2: m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~d;
        3'd3: m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | d;
        3'd4: m_swi[b*32 +: 32]  = m_swi[b*32 +: 32] | d;
        3'd5: m_swi[b*32 +: 32]  = m_swi[b*32 +: 32] & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic settle();
    wr(8'h04, 32'h3);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_sel(string tag);
    logic [31:0] d;
    rd(8'h02, d); chk({tag, " R6 sorted irq"}, d, exp_win(0));
    rd(8'h03, d); chk({tag, " R9 sorted fiq"}, d, exp_win(1));
    chk({tag, " R11 irq_o"}, irq_o, exp_win(0) != 127);
    chk({tag, " R11 fiq_o"}, fiq_o, exp_win(1) != 127);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", irq_o, 0);
    chk("R1 fiq_o", fiq_o, 0);
    rd(8'h01, d); chk("R1 status", d, 1);
    rd(8'h02, d); chk("R1 sorted irq none", d, 127);
    rd(8'h03, d); chk("R1 sorted fiq none", d, 127);
    rd(8'h11, d); chk("R1 mask bank0", d, 32'hFFFF_FFFF);
    rd(8'h45, d); chk("R9 level reset", d, 0);
    rd(8'h05, d); chk("R8 threshold reset", d, 8'hFF);

    // R2 write-one mask ports
    wr(8'h1A, 32'h0000_F00F);
    rd(8'h19, d); chk("R2 mask clear", d, 32'hFFFF_0FF0);
    wr(8'h1B, 32'h0000_0003);
    rd(8'h19, d); chk("R2 mask set", d, 32'hFFFF_0FF3);
    wr(8'h1B, 32'h0); wr(8'h1A, 32'h0);
    rd(8'h19, d); chk("R2 zero bits no effect", d, 32'hFFFF_0FF3);

    // R3 raw view ignores mask; R4/R11 masked source is not pending
    @(negedge clk); m_src[40] = 1;
    repeat (3) @(negedge clk);
    rd(8'h18, d); chk("R3 raw bank1", d, 32'h0000_0100);
    rd(8'h1E, d); chk("R4 pend irq masked", d, 0);
    chk("R11 irq_o masked", irq_o, 0);
    @(negedge clk); m_src[40] = 0;

    // R6 tie: equal priority, lower number wins
    for (int b = 0; b < 3; b++) wr(8'(8'h12 + 8*b), 32'hFFFF_FFFF);
    wr(8'h40 + 10, 3 << 2);
    wr(8'h40 + 70, 3 << 2);
    wr(8'h14, 32'h0000_0400);            // swi 10
    wr(8'h24, 32'h0000_0040);            // swi 70
    rd(8'h10, d); chk("R5 swi raw bank0", d, 32'h0000_0400);
    settle();
    rd(8'h02, d); chk("R6 tie lower index", d, 10);
    chk("R11 irq_o tie", irq_o, 1);

    // R7 hold until acknowledge
    wr(8'h40 + 70, 0);
    repeat (3) @(negedge clk);
    rd(8'h02, d); chk("R7 held before ack", d, 10);
    wr(8'h04, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h02, d); chk("R7 new after ack", d, 70);

    // R8 threshold
    wr(8'h40 + 70, 3 << 2);
    wr(8'h05, 3);
    settle();
    rd(8'h02, d); chk("R8 threshold blocks equal", d, 127);
    chk("R8 irq_o blocked", irq_o, 0);
    wr(8'h05, 4);
    settle();
    rd(8'h02, d); chk("R8 threshold admits below", d, 10);
    wr(8'h05, 8'hFF);

    // R9 FIQ route
    wr(8'h40 + 20, (5 << 2) | 1);
    wr(8'h14, 32'h0010_0000);
    settle();
    rd(8'h03, d); chk("R9 sorted fiq", d, 20);
    chk("R9 fiq_o", fiq_o, 1);
    rd(8'h17, d); chk("R4 pend fiq bank0", d, 32'h0010_0000);
    rd(8'h16, d); chk("R4 pend irq bank0", d, 32'h0000_0400);
    rd(8'h40 + 20, d); chk("R9 level readback", d, (5 << 2) | 1);

    // R5 software clear
    wr(8'h15, 32'h0010_0400);
    wr(8'h25, 32'h0000_0040);
    settle();
    check_sel("R5 after swi clear");

    // random phase
    for (int i = 0; i < NS; i++) wr(8'(8'h40 + i), {$urandom_range(63, 0), 2'b00} | ($urandom & 1));
    for (int it = 0; it < 50; it++) begin
      int b = $urandom_range(2, 0);
      @(negedge clk);
      m_src = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      wr(8'(8'h12 + 8*b), $urandom);
      wr(8'(8'h13 + 8*$urandom_range(2, 0)), $urandom & $urandom);
      wr(8'(8'h40 + $urandom_range(NS-1, 0)), {$urandom_range(63, 0), 2'b00} | ($urandom & 1));
      if (it % 4 == 3) wr(8'h05, $urandom_range(70, 0));
      else if (it % 4 == 0) wr(8'h05, 8'hFF);
      settle();
      check_sel("R6 random");
      rd(8'(8'h16 + 8*b), d);
      chk("R4 random pend irq", d, (m_src[b*32 +: 32] | m_swi[b*32 +: 32]) & ~m_mask[b*32 +: 32] & ~m_fiq[b*32 +: 32]);
    end

    // R10 soft reset
    wr(8'h00, 32'h2);
    @(negedge clk);
    rd(8'h01, d); chk("R10 status done", d, 1);
    rd(8'h21, d); chk("R10 mask restored", d, 32'hFFFF_FFFF);
    rd(8'h40 + 20, d); chk("R10 level cleared", d, 0);
    rd(8'h02, d); chk("R10 sorted cleared", d, 127);
    chk("R10 irq_o cleared", irq_o, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule